// File: doc/BRIEF.md
# Time-Shared Oscillator Recurrence Engine

The engine advances a bank of second-order sinusoid oscillators, one per multipath component, with a single shared multiplier. Each component holds a coefficient B (twice the cosine of its per-step phase increment) and two state words, the latest sample y1 and the one before it y2. An update tick starts a sweep. The slot controller then selects components one per clock cycle in ascending index order. It steers the selected coefficient and state through input multiplexers into the multiplier, forms B·y1 − y2 and writes the new sample back into that component's state pair. Each result also appears on the output port with its index and a one-cycle valid.

Sweeps are short compared with the spacing of ticks. At tens of kHz of updates against a clock near 100 MHz, a sweep of twenty slots leaves thousands of idle cycles. Software or a seeding block loads the coefficient and the two initial samples of each component through the load port while the engine is idle. A tick that arrives in the middle of a sweep is reported as an overrun and otherwise dropped.

Top module: `osc_slot_engine`

## Requirements
- R1: After reset, busy, out_valid and overrun are low, and every component's coefficient and state are zero.
- R2: A tick sampled while idle starts a sweep. out_valid is high for N_COMP consecutive cycles, beginning two cycles after the edge that samples the tick. During those cycles out_idx runs 0, 1, …, N_COMP−1.
- R3: The result for component k is ((B·y1) >>> FRAC) − y2, taken modulo 2^W as a W-bit signed value. B, y1 and y2 are W-bit two's complement, and B has FRAC fractional bits. Overflow wraps and does not saturate.
- R4: After a component's slot its state becomes y2 ← old y1 and y1 ← result. Components not in their slot keep their state, so successive sweeps continue each recurrence independently.
- R5: busy rises in the cycle after an accepted tick. It stays high for N_COMP+1 cycles and falls in the cycle that shows the last result.
- R6: A tick sampled while busy gives a one-cycle overrun pulse in the next cycle. It neither restarts nor lengthens the sweep in progress.
- R7: ld_en writes ld_coef, ld_y1 and ld_y2 into component ld_idx only while busy is low. A load presented while busy has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Update request; starts a sweep when idle |
| ld_en | input | 1 | Load strobe for one component |
| ld_idx | input | IW | Component index to load |
| ld_coef | input | W | Coefficient B, signed, FRAC fractional bits |
| ld_y1 | input | W | Latest sample to load |
| ld_y2 | input | W | Previous sample to load |
| busy | output | 1 | Sweep in progress |
| overrun | output | 1 | One-cycle pulse for a tick that arrived while busy |
| out_valid | output | 1 | A result is present this cycle |
| out_idx | output | IW | Component index of the result |
| out_val | output | W | New sample of that component |

## Verification
The assertions check the framing of a sweep on every cycle. Results start at index zero, step up by one, never pass N_COMP−1, and busy ends exactly on the last result. A tick during a sweep always produces an overrun pulse, and no pulse appears without one. The numbers themselves cannot be checked that way: correct wrap-around arithmetic, the state shift across sweeps, the isolation between components and the rejection of loads made while busy only show in the bench's scenarios. There the outputs of several sweeps are compared with a reference recurrence kept in the bench.

// File: rtl/osc_slot_engine.sv
module osc_slot_engine #(
  parameter int N_COMP = 20,
  parameter int W      = 16,
  parameter int FRAC   = 14,
  localparam int IW    = (N_COMP > 1) ? $clog2(N_COMP) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic                ld_en,
  input  logic [IW-1:0]       ld_idx,
  input  logic signed [W-1:0] ld_coef,
  input  logic signed [W-1:0] ld_y1,
  input  logic signed [W-1:0] ld_y2,
  output logic                busy,
  output logic                overrun,
  output logic                out_valid,
  output logic [IW-1:0]       out_idx,
  output logic signed [W-1:0] out_val
);

  localparam logic [IW-1:0] LAST = IW'(N_COMP - 1);

  logic                  issuing, v_q;
  logic [IW-1:0]         sel, idx_q;
  logic signed [2*W-1:0] prod_q, shifted;
  logic signed [W-1:0]   y2_q, res;
  logic signed [W-1:0]   coef [N_COMP];
  logic signed [W-1:0]   st1  [N_COMP];
  logic signed [W-1:0]   st2  [N_COMP];
  logic signed [W-1:0]   m_coef, m_y1, m_y2;
  logic [N_COMP-1:0]     hot;

  assign busy    = issuing | v_q;
  assign shifted = prod_q >>> FRAC;
  assign res     = shifted[W-1:0] - y2_q;

  always_comb begin
    m_coef = '0;
    m_y1   = '0;
    m_y2   = '0;
    for (int i = 0; i < N_COMP; i++) begin
      hot[i] = issuing && (sel == IW'(i));
      if (hot[i]) begin
        m_coef = m_coef | coef[i];
        m_y1   = m_y1 | st1[i];
        m_y2   = m_y2 | st2[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issuing   <= 1'b0;
      sel       <= '0;
      v_q       <= 1'b0;
      idx_q     <= '0;
      prod_q    <= '0;
      y2_q      <= '0;
      overrun   <= 1'b0;
      out_valid <= 1'b0;
      out_idx   <= '0;
      out_val   <= '0;
    end else begin
      overrun <= tick & busy;
      if (tick && !busy) begin
        issuing <= 1'b1;
        sel     <= '0;
      end else if (issuing) begin
        sel <= sel + 1'b1;
        if (sel == LAST) issuing <= 1'b0;
      end
      v_q       <= issuing;
      idx_q     <= sel;
      prod_q    <= m_coef * m_y1;
      y2_q      <= m_y2;
      out_valid <= v_q;
      out_idx   <= idx_q;
      out_val   <= res;
    end
  end

  for (genvar g = 0; g < N_COMP; g++) begin : g_comp
    logic wb, ld_hit;
    assign wb     = v_q && (idx_q == IW'(g));
    assign ld_hit = ld_en && !busy && (ld_idx == IW'(g));
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        coef[g] <= '0;
        st1[g]  <= '0;
        st2[g]  <= '0;
      end else if (ld_hit) begin
        coef[g] <= ld_coef;
        st1[g]  <= ld_y1;
        st2[g]  <= ld_y2;
      end else if (wb) begin
        st2[g] <= st1[g];
        st1[g] <= res;
      end
    end
  end

endmodule

// File: rtl/osc_slot_engine_chk.sv
module osc_slot_engine_chk #(
  parameter int N_COMP = 20,
  localparam int IW    = (N_COMP > 1) ? $clog2(N_COMP) : 1
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          busy,
  input logic          overrun,
  input logic          out_valid,
  input logic [IW-1:0] out_idx
);

  AST_OVERRUN_ON_BUSY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    tick && busy |=> overrun); // R6
  AST_OVERRUN_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(busy) && $past(tick)); // R6
  AST_SWEEP_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    tick && !busy |=> busy); // R5
  AST_FIRST_INDEX_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !$past(out_valid) |-> out_idx == '0); // R2
  AST_INDEX_ASCENDS: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) |-> out_idx == IW'($past(out_idx) + 1'b1)); // R2
  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_idx <= IW'(N_COMP - 1)); // R2
  AST_BUSY_ENDS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> out_valid && out_idx == IW'(N_COMP - 1)); // R5

endmodule

bind osc_slot_engine osc_slot_engine_chk #(.N_COMP(N_COMP)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .busy(busy), .overrun(overrun),
  .out_valid(out_valid), .out_idx(out_idx)
);

// File: tb/test_osc_slot_engine.sv
module test_osc_slot_engine;
  localparam int N    = 6;
  localparam int W    = 16;
  localparam int FRAC = 14;
  localparam int IW   = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, ld_en = 1'b0;
  logic [IW-1:0] ld_idx = '0;
  logic signed [W-1:0] ld_coef = '0, ld_y1 = '0, ld_y2 = '0;
  logic busy, overrun, out_valid;
  logic [IW-1:0] out_idx;
  logic signed [W-1:0] out_val;

  int total = 0, bad = 0;
  int mb [N], my1 [N], my2 [N];

  always #10 clk = ~clk;

  osc_slot_engine #(.N_COMP(N), .W(W), .FRAC(FRAC)) i_osc_slot_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .ld_en(ld_en), .ld_idx(ld_idx),
    .ld_coef(ld_coef), .ld_y1(ld_y1), .ld_y2(ld_y2), .busy(busy),
    .overrun(overrun), .out_valid(out_valid), .out_idx(out_idx), .out_val(out_val));

  function automatic int step(int b, int y1, int y2);
    longint p;
    longint s;
    logic signed [W-1:0] r;
    p = longint'(b) * longint'(y1);
    s = p >>> FRAC;
    r = W'(s - longint'(y2));
    return int'(r);
  endfunction

  task automatic check(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic load(int k, int b, int y1, int y2);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = IW'(k);
    ld_coef = W'(b); ld_y1 = W'(y1); ld_y2 = W'(y2);
    @(negedge clk);
    ld_en = 1'b0;
    mb[k] = int'(signed'(W'(b)));
    my1[k] = int'(signed'(W'(y1)));
    my2[k] = int'(signed'(W'(y2)));
  endtask

  task automatic sweep(int inject);
    int r;
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
    check("R5", "busy after tick", busy, 1);
    check("R2", "no result yet", out_valid, 0);
    @(negedge clk);
    check("R2", "no result one cycle on", out_valid, 0);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      tick = 1'b0; ld_en = 1'b0;
      r = step(mb[i], my1[i], my2[i]);
      check("R2", "out_valid", out_valid, 1);
      check("R2", "out_idx", int'(out_idx), i);
      check("R3", "out_val", int'(out_val), r);
      check("R5", "busy in sweep", busy, (i < N-1) ? 1 : 0);
      check("R6", "overrun", overrun, (inject >= 0 && i == inject + 1) ? 1 : 0);
      my2[i] = my1[i]; my1[i] = r;  // R4
      if (i == inject) begin
        tick = 1'b1;
        ld_en = 1'b1; ld_idx = '0; ld_coef = 16'sd1; ld_y1 = 16'sd1234; ld_y2 = 16'sd99;  // R7 ignored
      end
    end
    @(negedge clk);
    check("R2", "out_valid after sweep", out_valid, 0);
    check("R5", "idle after sweep", busy, 0);
  endtask

  initial begin
    #(20 * 200000);
    bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", "busy", busy, 0);
    check("R1", "out_valid", out_valid, 0);
    check("R1", "overrun", overrun, 0);
    rst_n = 1'b1;
    for (int k = 0; k < N; k++) begin mb[k] = 0; my1[k] = 0; my2[k] = 0; end
    // R1: zero state yields zero results
    sweep(-1);
    // R3 R4: oscillators, extremes and wrap
    load(0, 16'sh7000, 1000, 0);
    load(1, 16'sh8000, -32768, 5);
    load(2, 16'sh4000, 32767, -32768);
    load(3, -16'sh2000, -1200, 300);
    load(4, 16'sh7fff, 20000, 19000);
    load(5, 0, 77, -77);
    for (int s = 0; s < 5; s++) sweep(-1);
    // R6 R7: tick and load during sweeps are ignored
    sweep(0);
    sweep(N - 2);
    sweep(2);
    // R7: idle load accepted
    load(0, 16'sh3000, -500, 250);
    sweep(-1);
    sweep(-1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule